// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one output compare channel. Each cycle it takes the count of one timebase, picked from a bus of six counts, and compares it against two compare values, a primary and a secondary. The outcome drives a single output pin. A three-bit mode field picks the behaviour: off, a one-time set or clear, a continuous toggle, a single pulse or a continuous pulse train bounded by both compare values, and edge-aligned or center-aligned PWM.

Software programs the channel through a small write port with four addresses: control, primary, secondary and a trigger command. In the two PWM modes, writes to the compare values go to shadow copies. These copies load into the live registers when the selected count reaches zero. In every other mode a write takes effect at once.

Center-aligned PWM has a fault latch that forces the pin low, and only hardware clears it. A trigger status flag can clear itself on a secondary match. An idle-halt option freezes the channel while the idle input is high.

Top module: `ocmp_channel`

## Requirements
- R1: After reset, and whenever the mode is 000, `oc_out` is 0. Reset also clears `flt_stat` and `trig_stat`.
- R2: Mode 001 drives the output high on a primary match and keeps it high. Mode 010 drives it low on a primary match and keeps it low.
- R3: Mode 011 inverts the output on every primary match.
- R4: Mode 100 produces one pulse. While the output is low, a primary match sets it. A secondary match then clears it, and later matches have no effect until the control register is written again.
- R5: Mode 101 repeats the pattern of R4 without end: a primary match sets the output while it is low, and a secondary match clears it while it is high.
- R6: Mode 110 is edge-aligned PWM. A selected count of zero drives the output high, and a primary match drives it low. The match wins if both occur in the same cycle.
- R7: Mode 111 is center-aligned PWM. A primary match drives the output high, and a secondary match drives it low. The secondary match wins if both occur in the same cycle.
- R8: In modes 110 and 111, a compare write updates only a shadow copy. All shadow copies move to the live registers in a cycle where the selected count is zero. In all other modes a compare write updates the live value at the same edge.
- R9: `tb_counts` holds six counts; slot k occupies bits [k*CNT_W +: CNT_W]. Timebase select 0 to 3 uses slots 0 to 3, select 4 uses slot 4, and select 7 uses slot 5. Selects 5 and 6 produce no compare match and no zero detection.
- R10: In mode 111 with the fault enable set, a high `fault_in` sets `flt_stat` and forces the output low. Writes never clear `flt_stat`. It clears only in a cycle where the selected count is zero and the fault is not active. While it is set in mode 111, the output stays low.
- R11: A write to address 3 sets `trig_stat` if data bit 0 is set. It clears `trig_stat` if data bit 1 is set, and bit 1 wins when both are set. With the auto-clear bit set, a secondary match clears `trig_stat`. With that bit clear, only a write changes it.
- R12: With the idle-halt bit set and `idle_in` high, compare events, zero detection and fault capture are all suppressed, so the output and status hold. With the idle-halt bit clear, `idle_in` has no effect.
- R13: Address 0 is control. Its fields are mode in bits 2:0, timebase select in bits 5:3, fault enable in bit 6, auto-clear in bit 7 and idle-halt in bit 8. Address 1 is primary and address 2 is secondary. A control write resets the output to 1 for mode 010 and to 0 for every other mode, and it re-arms mode 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Write data |
| tb_counts | input | 6*CNT_W | Six timebase counts, packed by slot |
| fault_in | input | 1 | Fault request, active high |
| idle_in | input | 1 | Idle request, active high |
| oc_out | output | 1 | Compare output pin |
| flt_stat | output | 1 | Fault latch status |
| trig_stat | output | 1 | Trigger status |

## Verification
Every result is one register away from its cause. A count or a write presented during a cycle shows on `oc_out`, `flt_stat` or `trig_stat` right after the next rising edge. A compare write in a PWM mode waits longer: it first shows on the pin one edge after the selected count next reads zero. The bench changes inputs on the falling edge and samples a quarter period after the following rising edge, so each check reads the value that edge produced. The buffered-write case is checked before and after the reload edge to separate the two timings.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
    localparam int unsigned OM_NSRC = 6;
    localparam int unsigned OM_CTRL_W = 9;

    typedef enum logic [2:0] {
        OM_OFF      = 3'd0,
        OM_SS_HI    = 3'd1,
        OM_SS_LO    = 3'd2,
        OM_TOGGLE   = 3'd3,
        OM_DBL_ONE  = 3'd4,
        OM_DBL_CONT = 3'd5,
        OM_PWM_EDGE = 3'd6,
        OM_PWM_CTR  = 3'd7
    } om_mode_e;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_PRI  = 2'd1,
        RA_SEC  = 2'd2,
        RA_TRIG = 2'd3
    } om_addr_e;

    typedef struct packed {
        logic       idle_halt;
        logic       trig_auto;
        logic       flt_en;
        logic [2:0] tsel;
        om_mode_e   mode;
    } om_ctrl_t;

    function automatic logic is_pwm(om_mode_e m);
        return m[2] & m[1];
    endfunction
endpackage

// File: rtl/ocmp_tbsel.sv
module ocmp_tbsel
    import ocmp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic [OM_NSRC*CNT_W-1:0] counts,
    input  logic [2:0]               tsel,
    output logic [CNT_W-1:0]         cnt,
    output logic                     cnt_ok
);
    function automatic logic [2:0] code_of(int unsigned s);
        logic [2:0] c;
        c = (s == OM_NSRC - 1) ? 3'd7 : s[2:0];
        return c;
    endfunction

    logic [OM_NSRC-1:0] hit;

    for (genvar g = 0; g < OM_NSRC; g++) begin : g_slot
        assign hit[g] = (tsel == code_of(g));
    end

    always_comb begin
        cnt = '0;
        for (int s = 0; s < OM_NSRC; s++) begin
            if (hit[s]) cnt = cnt | counts[s*CNT_W +: CNT_W];
        end
    end

    assign cnt_ok = |hit;
endmodule

// File: rtl/ocmp_cmpregs.sv
module ocmp_cmpregs #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pri,
    input  logic             wr_sec,
    input  logic [CNT_W-1:0] wdata,
    input  logic             buffered,
    input  logic             reload,
    output logic [CNT_W-1:0] pri_act,
    output logic [CNT_W-1:0] sec_act
);
    localparam int unsigned NREG = 2;

    typedef struct packed {
        logic [NREG-1:0][CNT_W-1:0] shadow;
        logic [NREG-1:0][CNT_W-1:0] active;
    } regs_t;

    regs_t r_d, r_q;
    logic [NREG-1:0] wr;

    assign wr = {wr_sec, wr_pri};

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NREG; i++) begin
            if (reload) r_d.active[i] = r_q.shadow[i];
            if (wr[i]) begin
                r_d.shadow[i] = wdata;
                if (!buffered) r_d.active[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pri_act = r_q.active[0];
    assign sec_act = r_q.active[1];
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [1:0]               reg_addr,
    input  logic [CNT_W-1:0]         reg_wdata,
    input  logic [OM_NSRC*CNT_W-1:0] tb_counts,
    input  logic                     fault_in,
    input  logic                     idle_in,
    output logic                     oc_out,
    output logic                     flt_stat,
    output logic                     trig_stat
);
    typedef struct packed {
        om_ctrl_t ctrl;
        logic     out;
        logic     done;
        logic     flt;
        logic     trig;
    } state_t;

    state_t s_d, s_q;

    logic             ctrl_wr, pri_wr, sec_wr, trig_wr;
    logic [CNT_W-1:0] sel_cnt, pri_act, sec_act;
    logic             sel_ok, frozen, pwm, trig_auto;
    logic             hit_p, hit_s, at_zero, flt_trip;
    om_mode_e         cur_mode;

    assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);
    assign pri_wr  = reg_we && (reg_addr == RA_PRI);
    assign sec_wr  = reg_we && (reg_addr == RA_SEC);
    assign trig_wr = reg_we && (reg_addr == RA_TRIG);

    assign cur_mode  = s_q.ctrl.mode;
    assign trig_auto = s_q.ctrl.trig_auto;
    assign frozen    = s_q.ctrl.idle_halt & idle_in;
    assign pwm       = is_pwm(cur_mode);

    ocmp_tbsel #(.CNT_W(CNT_W)) u_sel (
        .counts (tb_counts),
        .tsel   (s_q.ctrl.tsel),
        .cnt    (sel_cnt),
        .cnt_ok (sel_ok)
    );

    assign hit_p   = sel_ok && !frozen && (sel_cnt == pri_act);
    assign hit_s   = sel_ok && !frozen && (sel_cnt == sec_act);
    assign at_zero = sel_ok && !frozen && (sel_cnt == '0);
    assign flt_trip = (cur_mode == OM_PWM_CTR) && s_q.ctrl.flt_en
                      && fault_in && !frozen;

    ocmp_cmpregs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pri   (pri_wr),
        .wr_sec   (sec_wr),
        .wdata    (reg_wdata),
        .buffered (pwm),
        .reload   (pwm && at_zero),
        .pri_act  (pri_act),
        .sec_act  (sec_act)
    );

    always_comb begin
        s_d = s_q;
        case (cur_mode)
            OM_OFF:   s_d.out = 1'b0;
            OM_SS_HI: if (hit_p) s_d.out = 1'b1;
            OM_SS_LO: if (hit_p) s_d.out = 1'b0;
            OM_TOGGLE: if (hit_p) s_d.out = ~s_q.out;
            OM_DBL_ONE: begin
                if (!s_q.done) begin
                    if (!s_q.out && hit_p) begin
                        s_d.out = 1'b1;
                    end else if (s_q.out && hit_s) begin
                        s_d.out  = 1'b0;
                        s_d.done = 1'b1;
                    end
                end
            end
            OM_DBL_CONT: begin
                if (!s_q.out && hit_p)     s_d.out = 1'b1;
                else if (s_q.out && hit_s) s_d.out = 1'b0;
            end
            OM_PWM_EDGE: begin
                if (hit_p)        s_d.out = 1'b0;
                else if (at_zero) s_d.out = 1'b1;
            end
            OM_PWM_CTR: begin
                if (flt_trip) begin
                    s_d.flt = 1'b1;
                    s_d.out = 1'b0;
                end else if (s_q.flt && !at_zero) begin
                    s_d.out = 1'b0;
                end else begin
                    if (at_zero) s_d.flt = 1'b0;
                    if (hit_s)      s_d.out = 1'b0;
                    else if (hit_p) s_d.out = 1'b1;
                end
            end
            default: s_d.out = 1'b0;
        endcase

        if (trig_auto && hit_s) s_d.trig = 1'b0;
        if (trig_wr) begin
            if (reg_wdata[1])      s_d.trig = 1'b0;
            else if (reg_wdata[0]) s_d.trig = 1'b1;
        end

        if (ctrl_wr) begin
            s_d.ctrl = om_ctrl_t'(reg_wdata[OM_CTRL_W-1:0]);
            s_d.out  = (om_mode_e'(reg_wdata[2:0]) == OM_SS_LO);
            s_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign oc_out    = s_q.out;
    assign flt_stat  = s_q.flt;
    assign trig_stat = s_q.trig;
endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             trig_wr,
    input logic [2:0]       cur_mode,
    input logic             trig_auto,
    input logic             frozen,
    input logic [CNT_W-1:0] sel_cnt,
    input logic             sel_ok,
    input logic [CNT_W-1:0] sec_act,
    input logic             oc_out,
    input logic             flt_stat,
    input logic             trig_stat
);
    p_off_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0) |-> !oc_out);

    p_set_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd1 && oc_out && !ctrl_wr) |=> oc_out);

    p_fault_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd7 && flt_stat) |-> !oc_out);

    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stat && !(sel_ok && sel_cnt == '0 && !frozen)) |=> flt_stat);

    p_trig_auto_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_auto && sel_ok && !frozen && sel_cnt == sec_act && !trig_wr)
        |=> !trig_stat);

    p_trig_sw_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_auto && !trig_wr) |=> $stable(trig_stat));

    p_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !ctrl_wr) |=> ($stable(oc_out) && $stable(flt_stat)));
endmodule

bind ocmp_channel ocmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .trig_wr   (trig_wr),
    .cur_mode  (cur_mode),
    .trig_auto (trig_auto),
    .frozen    (frozen),
    .sel_cnt   (sel_cnt),
    .sel_ok    (sel_ok),
    .sec_act   (sec_act),
    .oc_out    (oc_out),
    .flt_stat  (flt_stat),
    .trig_stat (trig_stat)
);

// File: tb/ocmp_channel_tb.sv
module ocmp_channel_tb_top;
    localparam int unsigned W    = 16;
    localparam int unsigned NS   = 6;
    localparam time         TCLK = 10ns;
    localparam logic [W-1:0] C   = 16'h00FF;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [1:0]     reg_addr = '0;
    logic [W-1:0]   reg_wdata = '0;
    logic [NS*W-1:0] tb_counts;
    logic           fault_in = 1'b0;
    logic           idle_in = 1'b0;
    logic           oc_out, flt_stat, trig_stat;
    logic [W-1:0]   cnt_s [NS];

    int total = 0;
    int bad   = 0;

    always #(TCLK/2) clk = ~clk;

    always_comb begin
        for (int k = 0; k < NS; k++) tb_counts[k*W +: W] = cnt_s[k];
    end

    ocmp_channel #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tb_counts(tb_counts), .fault_in(fault_in),
        .idle_in(idle_in), .oc_out(oc_out), .flt_stat(flt_stat),
        .trig_stat(trig_stat)
    );

    // vector: we, addr, data, slot-0 count, fault, exp out, exp fault, req
    function automatic logic [41:0] mk(logic we, logic [1:0] a, logic [15:0] d,
                                       logic [15:0] c, logic f, logic eo,
                                       logic ef, logic [3:0] rq);
        return {we, a, d, c, f, eo, ef, rq};
    endfunction

    localparam int NV = 47;
    localparam logic [41:0] VEC [NV] = '{
        mk(1,1,16'd3,C,0,0,0,1),     // R1 primary=3, mode off
        mk(1,2,16'd5,C,0,0,0,8),     // R8 secondary=5
        mk(0,0,0,16'd3,0,0,0,1),     // R1 match ignored when off
        mk(1,0,16'h1,C,0,0,0,13),    // R13 mode 001
        mk(0,0,0,16'd2,0,0,0,2),     // R2
        mk(0,0,0,16'd3,0,1,0,2),     // R2 set
        mk(0,0,0,16'd4,0,1,0,2),
        mk(0,0,0,16'd3,0,1,0,2),
        mk(1,0,16'h2,C,0,1,0,13),    // R13 mode 010 starts high
        mk(0,0,0,16'd3,0,0,0,2),     // R2 clear
        mk(0,0,0,16'd4,0,0,0,2),
        mk(1,0,16'h3,C,0,0,0,3),     // R3 mode 011
        mk(0,0,0,16'd3,0,1,0,3),
        mk(0,0,0,16'd4,0,1,0,3),
        mk(0,0,0,16'd3,0,0,0,3),
        mk(1,0,16'h4,C,0,0,0,4),     // R4 mode 100
        mk(0,0,0,16'd5,0,0,0,4),
        mk(0,0,0,16'd3,0,1,0,4),
        mk(0,0,0,16'd5,0,0,0,4),
        mk(0,0,0,16'd3,0,0,0,4),     // R4 one pulse only
        mk(1,0,16'h5,C,0,0,0,5),     // R5 mode 101
        mk(0,0,0,16'd3,0,1,0,5),
        mk(0,0,0,16'd5,0,0,0,5),
        mk(0,0,0,16'd3,0,1,0,5),
        mk(0,0,0,16'd5,0,0,0,5),
        mk(1,0,16'h6,C,0,0,0,6),     // R6 mode 110
        mk(0,0,0,16'd0,0,1,0,6),
        mk(0,0,0,16'd2,0,1,0,6),
        mk(0,0,0,16'd3,0,0,0,6),
        mk(1,1,16'd1,16'd4,0,0,0,8), // R8 buffered write
        mk(0,0,0,16'd1,0,0,0,8),     // R8 old value still live
        mk(0,0,0,16'd0,0,1,0,8),
        mk(0,0,0,16'd1,0,0,0,8),     // R8 new value live
        mk(1,0,16'h7,C,0,0,0,7),     // R7 mode 111
        mk(0,0,0,16'd0,0,0,0,7),
        mk(0,0,0,16'd1,0,1,0,7),
        mk(0,0,0,16'd5,0,0,0,7),
        mk(1,0,16'h47,C,0,0,0,10),   // R10 fault enabled
        mk(0,0,0,16'd1,0,1,0,10),
        mk(0,0,0,16'd2,1,0,1,10),
        mk(0,0,0,16'd5,0,0,1,10),
        mk(0,0,0,16'd1,0,0,1,10),
        mk(0,0,0,16'd0,0,0,0,10),
        mk(0,0,0,16'd1,0,1,0,10),
        mk(0,0,0,16'd2,1,0,1,10),
        mk(0,0,0,16'd0,1,0,1,10),
        mk(0,0,0,16'd0,0,0,0,10)
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic set_all(input logic [W-1:0] v);
        for (int k = 0; k < NS; k++) cnt_s[k] = v;
    endtask

    task automatic step(input logic we, input logic [1:0] a, input logic [W-1:0] d,
                        input logic f, input logic idl);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; fault_in = f; idle_in = idl;
        @(posedge clk);
        #(TCLK/4);
        reg_we = 1'b0;
    endtask

    initial begin
        #(TCLK*50000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        set_all(C);
        repeat (3) @(posedge clk);
        #(TCLK/4);
        chk("R1 reset out", oc_out, 1'b0);
        chk("R1 reset fault", flt_stat, 1'b0);
        chk("R1 reset trig", trig_stat, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = VEC[i];
            set_all(C);
            cnt_s[0] = v[22:7];
            step(v[41], v[40:39], v[38:23], v[6], 1'b0);
            chk($sformatf("R%0d step %0d out", v[3:0], i), oc_out, v[5]);
            chk($sformatf("R%0d step %0d fault", v[3:0], i), flt_stat, v[4]);
        end

        // R9 timebase selection
        set_all(C);
        step(1, 0, 16'h000B, 0, 0);            // toggle, select 1
        step(1, 1, 16'd3, 0, 0);               // R8 immediate in non-PWM mode
        cnt_s[0] = 16'd3;
        step(0, 0, 0, 0, 0);
        chk("R9 unselected slot", oc_out, 1'b0);
        set_all(C); cnt_s[1] = 16'd3;
        step(0, 0, 0, 0, 0);
        chk("R9 select 1 slot 1", oc_out, 1'b1);
        set_all(C);
        step(1, 0, 16'h0023, 0, 0);            // select 4
        cnt_s[4] = 16'd3;
        step(0, 0, 0, 0, 0);
        chk("R9 select 4 slot 4", oc_out, 1'b1);
        set_all(C);
        step(1, 0, 16'h003B, 0, 0);            // select 7
        cnt_s[5] = 16'd3;
        step(0, 0, 0, 0, 0);
        chk("R9 select 7 slot 5", oc_out, 1'b1);
        step(1, 0, 16'h002B, 0, 0);            // select 5 reserved
        set_all(16'd3);
        step(0, 0, 0, 0, 0);
        chk("R9 reserved select a", oc_out, 1'b0);
        step(0, 0, 0, 0, 0);
        chk("R9 reserved select b", oc_out, 1'b0);

        // R11 trigger status
        set_all(C);
        step(1, 0, 16'h0003, 0, 0);
        step(1, 3, 16'h0001, 0, 0);
        chk("R11 software set", trig_stat, 1'b1);
        cnt_s[0] = 16'd5;
        step(0, 0, 0, 0, 0);
        chk("R11 no auto clear", trig_stat, 1'b1);
        cnt_s[0] = C;
        step(1, 0, 16'h0083, 0, 0);
        chk("R11 kept over ctrl write", trig_stat, 1'b1);
        cnt_s[0] = 16'd5;
        step(0, 0, 0, 0, 0);
        chk("R11 auto clear", trig_stat, 1'b0);
        cnt_s[0] = C;
        step(1, 3, 16'h0001, 0, 0);
        chk("R11 set again", trig_stat, 1'b1);
        step(1, 3, 16'h0003, 0, 0);
        chk("R11 clear wins", trig_stat, 1'b0);

        // R12 idle freeze
        step(1, 0, 16'h0103, 0, 0);
        cnt_s[0] = 16'd3;
        step(0, 0, 0, 0, 1);
        chk("R12 frozen a", oc_out, 1'b0);
        step(0, 0, 0, 0, 1);
        chk("R12 frozen b", oc_out, 1'b0);
        step(0, 0, 0, 0, 0);
        chk("R12 resumes", oc_out, 1'b1);
        cnt_s[0] = C;
        step(1, 0, 16'h0003, 0, 0);
        cnt_s[0] = 16'd3;
        step(0, 0, 0, 0, 1);
        chk("R12 idle ignored without halt", oc_out, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule